// File: doc/BRIEF.md
# Configurable Macrocell Storage Register

This block is the storage element of one programmable-logic macrocell. Static configuration inputs decide which of several candidate clocks drives the register and which of four sources acts as its clock enable. A separate set of configuration bits chooses how the register is asynchronously forced. Each macrocell may use its own local set term and local reset term. It may also listen to an initialization line that one logic block shares among all of its registers. A swap bit exchanges the set and reset roles.

While the power-up hold input is high, the register sits at its power-up value and ignores every clock. That value follows from the same set/reset mapping: 1 only when the shared initialization line is in use and the swap bit is set, otherwise 0. The configuration inputs pass into the block only during that hold. After the hold is released they are frozen, so later changes on those pins have no effect.

All pins are plain control and data levels. There is no streaming interface and no back-pressure.

Top module: `mc_macrocell_reg`

## Requirements
- R1: While `por_hold` is high, `q` equals 1 if `cfg_init_en`=1 and `cfg_swap`=1, and 0 in every other case, and clock edges are ignored. When the hold is released, `q` keeps that value until some other event changes it.
- R2: `cfg_clk_sel` picks the register clock. Codes 0..3 select the rising edge of `blk_clk[0..3]`, code 4 the rising edge of `pt_clk`, code 5 the falling edge of `pt_clk`, and code 6 the rising edge of `shared_pt_clk`. Code 7 selects a constant 0, and the register is then never clocked. Edges on unselected sources have no effect.
- R3: `cfg_ce_sel` picks the clock enable. Code 0 selects `ce_pt`, code 1 selects `~ce_pt`, code 2 selects the level of `shared_pt_clk`, and code 3 selects constant 1. At a selected clock edge `q` takes `d` when the enable is 1 and holds its value otherwise.
- R4: With `cfg_swap`=0, `pt_set` (gated by `cfg_lset_en`) forces `q` to 1 asynchronously. In the same mode, `pt_rst` (gated by `cfg_lrst_en`) forces `q` to 0 asynchronously.
- R5: With `cfg_swap`=1 the two local terms trade roles. An enabled `pt_set` forces `q` to 0, and an enabled `pt_rst` forces `q` to 1.
- R6: With `cfg_init_en`=1, `blk_init` acts as a reset when `cfg_swap`=0 and as a set when `cfg_swap`=1. When `cfg_init_en`=0, `blk_init` is ignored. A local term whose enable is 0 is also ignored.
- R7: When both an effective set and an effective reset are active after the swap mapping, `q` is 0.
- R8: The configuration inputs are taken only while `por_hold` is high. Changes to them after release do not alter clocking, enable or power-up behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| blk_clk | input | NUM_BLK_CLK | Block-level clock candidates |
| pt_clk | input | 1 | Product-term clock candidate (true and inverted) |
| shared_pt_clk | input | 1 | Shared product-term clock; also a clock-enable source |
| ce_pt | input | 1 | Initialization/enable product term used as clock enable |
| pt_set | input | 1 | Local set product term |
| pt_rst | input | 1 | Local reset product term |
| blk_init | input | 1 | Initialization line shared across the logic block |
| por_hold | input | 1 | High during power-up and the reset delay |
| d | input | 1 | Register data input |
| cfg_clk_sel | input | SEL_W | Clock source code |
| cfg_ce_sel | input | 2 | Clock-enable source code |
| cfg_init_en | input | 1 | Connect the shared initialization line |
| cfg_lset_en | input | 1 | Enable the local set term |
| cfg_lrst_en | input | 1 | Enable the local reset term |
| cfg_swap | input | 1 | Exchange set and reset roles |
| q | output | 1 | Register value |

## Verification
The asynchronous forces (local terms, block initialization, and entry into the power-up hold) change `q` in the same time step as their cause. The bench therefore samples one time unit after it drives them, with no clock edge in between. A capture appears one time unit after the selected clock edge, and the bench makes that edge itself by pulsing the source between edges of the free-running `blk_clk[0]`. The one exception is clock code 0, where the bench waits for the next rising edge of `blk_clk[0]` and samples at the following falling edge. For code 5 the bench samples between the rise and the fall of `pt_clk`, which tells the inverted clock apart from the true one.

// File: rtl/mc_reg_pkg.sv
package mc_reg_pkg;

  // clock-enable source codes
  typedef enum logic [1:0] {
    CE_FROM_PT     = 2'd0,
    CE_FROM_PT_N   = 2'd1,
    CE_FROM_SHARED = 2'd2,
    CE_ALWAYS      = 2'd3
  } ce_src_e;

  // clock candidates beyond the block clocks: pt, pt inverted, shared, ground
  localparam int EXTRA_CLK_SRC = 4;

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel
  import mc_reg_pkg::*;
#(
  parameter  int NUM_BLK_CLK = 4,
  localparam int NUM_SRC     = NUM_BLK_CLK + EXTRA_CLK_SRC,
  localparam int SEL_W       = $clog2(NUM_SRC)
) (
  input  logic [NUM_BLK_CLK-1:0] blk_clk_i,
  input  logic                   pt_clk_i,
  input  logic                   shared_clk_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic                   clk_o
);

  logic [NUM_SRC-1:0] cand;

  for (genvar g = 0; g < NUM_BLK_CLK; g++) begin : g_blk
    assign cand[g] = blk_clk_i[g];
  end
  assign cand[NUM_BLK_CLK]     = pt_clk_i;
  assign cand[NUM_BLK_CLK + 1] = ~pt_clk_i;
  assign cand[NUM_BLK_CLK + 2] = shared_clk_i;
  assign cand[NUM_BLK_CLK + 3] = 1'b0;

  always_comb begin
    clk_o = 1'b0;
    if (int'(sel_i) < NUM_SRC) clk_o = cand[sel_i];
  end

endmodule

// File: rtl/mc_ce_sel.sv
module mc_ce_sel
  import mc_reg_pkg::*;
(
  input  logic       ce_pt_i,
  input  logic       shared_clk_i,
  input  logic [1:0] sel_i,
  output logic       ce_o
);

  always_comb begin
    unique case (ce_src_e'(sel_i))
      CE_FROM_PT:     ce_o = ce_pt_i;
      CE_FROM_PT_N:   ce_o = ~ce_pt_i;
      CE_FROM_SHARED: ce_o = shared_clk_i;
      default:        ce_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/mc_init_ctl.sv
module mc_init_ctl (
  input  logic por_hold_i,
  input  logic init_en_i,
  input  logic lset_en_i,
  input  logic lrst_en_i,
  input  logic swap_i,
  input  logic blk_init_i,
  input  logic pt_set_i,
  input  logic pt_rst_i,
  output logic set_o,
  output logic rst_o
);

  logic set_src, rst_src;
  logic map_set, map_rst;
  logic pu_val;

  // unswapped roles: local set term, local reset term plus block init
  assign set_src = lset_en_i & pt_set_i;
  assign rst_src = (lrst_en_i & pt_rst_i) | (init_en_i & blk_init_i);

  assign map_set = swap_i ? rst_src : set_src;
  assign map_rst = swap_i ? set_src : rst_src;

  // power-up follows the block-init mapping
  assign pu_val = init_en_i & swap_i;

  // reset dominates; set is only raised when no reset is active
  assign rst_o = por_hold_i ? ~pu_val : map_rst;
  assign set_o = por_hold_i ?  pu_val : (map_set & ~map_rst);

endmodule

// File: rtl/mc_cfg_hold.sv
module mc_cfg_hold #(
  parameter int WIDTH = 9
) (
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // transparent while power-up hold is high, frozen afterwards
  always_latch begin
    if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk_i,
  input  logic set_i,
  input  logic rst_i,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk_i or posedge set_i or posedge rst_i) begin
    if (rst_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (ce_i)  q_o <= d_i;
  end

endmodule

// File: rtl/mc_macrocell_reg.sv
module mc_macrocell_reg
  import mc_reg_pkg::*;
#(
  parameter  int NUM_BLK_CLK = 4,
  localparam int SEL_W       = $clog2(NUM_BLK_CLK + EXTRA_CLK_SRC)
) (
  input  logic [NUM_BLK_CLK-1:0] blk_clk,
  input  logic                   pt_clk,
  input  logic                   shared_pt_clk,
  input  logic                   ce_pt,
  input  logic                   pt_set,
  input  logic                   pt_rst,
  input  logic                   blk_init,
  input  logic                   por_hold,
  input  logic                   d,
  input  logic [SEL_W-1:0]       cfg_clk_sel,
  input  logic [1:0]             cfg_ce_sel,
  input  logic                   cfg_init_en,
  input  logic                   cfg_lset_en,
  input  logic                   cfg_lrst_en,
  input  logic                   cfg_swap,
  output logic                   q
);

  localparam int CFG_W = SEL_W + 6;

  logic [CFG_W-1:0] cfg_in, cfg_q;
  logic [SEL_W-1:0] cfg_q_clk_sel;
  logic [1:0]       cfg_q_ce_sel;
  logic             cfg_q_init_en, cfg_q_lset_en, cfg_q_lrst_en, cfg_q_swap;
  logic             reg_clk, reg_ce, async_set, async_rst;

  assign cfg_in = {cfg_clk_sel, cfg_ce_sel, cfg_init_en,
                   cfg_lset_en, cfg_lrst_en, cfg_swap};

  mc_cfg_hold #(.WIDTH(CFG_W)) u_cfg (
    .load_i (por_hold),
    .d_i    (cfg_in),
    .q_o    (cfg_q)
  );

  assign {cfg_q_clk_sel, cfg_q_ce_sel, cfg_q_init_en,
          cfg_q_lset_en, cfg_q_lrst_en, cfg_q_swap} = cfg_q;

  mc_clk_sel #(.NUM_BLK_CLK(NUM_BLK_CLK)) u_clk (
    .blk_clk_i    (blk_clk),
    .pt_clk_i     (pt_clk),
    .shared_clk_i (shared_pt_clk),
    .sel_i        (cfg_q_clk_sel),
    .clk_o        (reg_clk)
  );

  mc_ce_sel u_ce (
    .ce_pt_i      (ce_pt),
    .shared_clk_i (shared_pt_clk),
    .sel_i        (cfg_q_ce_sel),
    .ce_o         (reg_ce)
  );

  mc_init_ctl u_init (
    .por_hold_i (por_hold),
    .init_en_i  (cfg_q_init_en),
    .lset_en_i  (cfg_q_lset_en),
    .lrst_en_i  (cfg_q_lrst_en),
    .swap_i     (cfg_q_swap),
    .blk_init_i (blk_init),
    .pt_set_i   (pt_set),
    .pt_rst_i   (pt_rst),
    .set_o      (async_set),
    .rst_o      (async_rst)
  );

  mc_store u_store (
    .clk_i (reg_clk),
    .set_i (async_set),
    .rst_i (async_rst),
    .ce_i  (reg_ce),
    .d_i   (d),
    .q_o   (q)
  );

endmodule

// File: rtl/mc_macrocell_reg_chk.sv
module mc_macrocell_reg_chk #(
  parameter  int NUM_BLK_CLK = 4,
  localparam int SEL_W       = $clog2(NUM_BLK_CLK + 4)
) (
  input logic             mon_clk,
  input logic             por_hold,
  input logic             init_en,
  input logic             swap,
  input logic             q,
  input logic             set_act,
  input logic             rst_act,
  input logic [SEL_W-1:0] clk_sel_q
);

  localparam logic [SEL_W-1:0] GND_CODE = SEL_W'(NUM_BLK_CLK + 3);

  logic quiet_gnd;
  assign quiet_gnd = !por_hold && !set_act && !rst_act && (clk_sel_q == GND_CODE);

  // R1
  por_value_chk: assert property (@(posedge mon_clk)
    por_hold && $past(por_hold) |-> q == (init_en & swap));

  // R7
  rst_win_chk: assert property (@(posedge mon_clk) disable iff (por_hold)
    rst_act && $past(rst_act) |-> !q);

  // R4
  set_act_chk: assert property (@(posedge mon_clk) disable iff (por_hold)
    set_act && $past(set_act) |-> q);

  // R2
  gnd_hold_chk: assert property (@(posedge mon_clk) disable iff (por_hold)
    quiet_gnd && $past(quiet_gnd) |-> $stable(q));

endmodule

bind mc_macrocell_reg mc_macrocell_reg_chk #(.NUM_BLK_CLK(NUM_BLK_CLK)) u_chk (
  .mon_clk   (blk_clk[0]),
  .por_hold  (por_hold),
  .init_en   (cfg_init_en),
  .swap      (cfg_swap),
  .q         (q),
  .set_act   (async_set),
  .rst_act   (async_rst),
  .clk_sel_q (cfg_q_clk_sel)
);

// File: tb/mc_macrocell_reg_tb_top.sv
module mc_macrocell_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;

  logic       clk0 = 1'b0;
  logic [2:0] bclk_hi = '0;
  logic [3:0] blk_clk;
  logic pt_clk = 0, shared_pt_clk = 0, ce_pt = 0, pt_set = 0, pt_rst = 0;
  logic blk_init = 0, por_hold = 1, d = 0;
  logic [2:0] cfg_clk_sel = 0;
  logic [1:0] cfg_ce_sel = 3;
  logic cfg_init_en = 0, cfg_lset_en = 0, cfg_lrst_en = 0, cfg_swap = 0;
  logic q;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign blk_clk = {bclk_hi, clk0};
  always #HALF clk0 = ~clk0;

  mc_macrocell_reg #(.NUM_BLK_CLK(4)) dut_i (
    .blk_clk(blk_clk), .pt_clk(pt_clk), .shared_pt_clk(shared_pt_clk),
    .ce_pt(ce_pt), .pt_set(pt_set), .pt_rst(pt_rst), .blk_init(blk_init),
    .por_hold(por_hold), .d(d), .cfg_clk_sel(cfg_clk_sel),
    .cfg_ce_sel(cfg_ce_sel), .cfg_init_en(cfg_init_en),
    .cfg_lset_en(cfg_lset_en), .cfg_lrst_en(cfg_lrst_en),
    .cfg_swap(cfg_swap), .q(q)
  );

  task automatic chk(input logic exp, input string req, input string what);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s %s: q=%b expected %b", req, what, q, exp);
    end
  endtask

  task automatic do_cfg(input logic [2:0] cs, input logic [1:0] ce,
                        input logic ie, input logic ls, input logic lr, input logic sw);
    @(negedge clk0);
    por_hold = 1; d = 0; pt_set = 0; pt_rst = 0; blk_init = 0;
    cfg_clk_sel = cs; cfg_ce_sel = ce;
    cfg_init_en = ie; cfg_lset_en = ls; cfg_lrst_en = lr; cfg_swap = sw;
    repeat (2) @(negedge clk0);
    por_hold = 0;
    #1;
  endtask

  // source codes 1..6 that the bench drives by hand
  task automatic pulse(input int src);
    @(negedge clk0);
    #1;
    case (src)
      1, 2, 3: bclk_hi[src-1] = 1'b1;
      4, 5:    pt_clk = 1'b1;
      default: shared_pt_clk = 1'b1;
    endcase
    #2;
    case (src)
      1, 2, 3: bclk_hi[src-1] = 1'b0;
      4, 5:    pt_clk = 1'b0;
      default: shared_pt_clk = 1'b0;
    endcase
    #1;
  endtask

  task automatic test_power_up;
    for (int k = 0; k < 3; k++) begin
      logic ie, sw, exp;
      ie = (k != 0); sw = (k != 1); exp = ie & sw;
      @(negedge clk0);
      por_hold = 1; cfg_clk_sel = 0; cfg_ce_sel = 3;
      cfg_init_en = ie; cfg_swap = sw; cfg_lset_en = 0; cfg_lrst_en = 0;
      d = ~exp;
      repeat (3) @(negedge clk0);
      chk(exp, "R1", "held during power-up, clock ignored");
      d = exp;
      por_hold = 0;
      #1;
      chk(exp, "R1", "value after hold release");
    end
  endtask

  task automatic test_clk_sel;
    for (int s = 0; s < 8; s++) begin
      do_cfg(3'(s), 2'd3, 0, 0, 0, 0);
      d = 1;
      if (s == 0) begin
        #1 chk(1'b0, "R2", "code 0 before edge");
        @(negedge clk0);
        chk(1'b1, "R2", "code 0 captures on blk_clk[0]");
      end else begin
        for (int o = 1; o < 7; o++)
          if (o != s && !(s inside {4, 5} && o inside {4, 5})) pulse(o);
        chk(1'b0, "R2", "unselected edges ignored");
        if (s == 7) begin
          pulse(4); pulse(1);
          chk(1'b0, "R2", "ground code never clocks");
        end else if (s == 4 || s == 5) begin
          @(negedge clk0);
          #1 pt_clk = 1;
          #1 chk(s == 4, "R2", "pt clock after rising edge");
          pt_clk = 0;
          #1 chk(1'b1, "R2", "pt clock after falling edge");
        end else begin
          pulse(s);
          chk(1'b1, "R2", "selected edge captures");
        end
      end
    end
  endtask

  task automatic test_ce;
    for (int c = 0; c < 4; c++) begin
      do_cfg(3'd1, 2'(c), 0, 0, 0, 0);
      d = 1;
      ce_pt = (c == 1); shared_pt_clk = 0;
      if (c != 3) begin
        pulse(1);
        chk(1'b0, "R3", "enable off holds");
      end
      ce_pt = (c == 0); shared_pt_clk = (c == 2);
      pulse(1);
      chk(1'b1, "R3", "enable on captures");
      shared_pt_clk = 0; ce_pt = 0;
    end
  endtask

  task automatic test_local;
    do_cfg(3'd7, 2'd3, 0, 1, 1, 0);
    pt_set = 1; #1 chk(1'b1, "R4", "local set");
    pt_set = 0; #1 chk(1'b1, "R4", "value held after set");
    pt_rst = 1; #1 chk(1'b0, "R4", "local reset");
    pt_set = 1; #1 chk(1'b0, "R7", "reset wins over set");
    pt_set = 0; pt_rst = 0;
    do_cfg(3'd7, 2'd3, 0, 1, 1, 1);
    pt_rst = 1; #1 chk(1'b1, "R5", "swapped reset term sets");
    pt_rst = 0; #1;
    pt_set = 1; #1 chk(1'b0, "R5", "swapped set term resets");
    pt_rst = 1; #1 chk(1'b0, "R7", "both terms after swap");
    pt_set = 0; pt_rst = 0;
    do_cfg(3'd7, 2'd3, 0, 0, 0, 0);
    pt_set = 1; #1 chk(1'b0, "R6", "disabled local set ignored");
    pt_set = 0;
    do_cfg(3'd7, 2'd3, 1, 0, 0, 1);
    pt_rst = 1; #1 chk(1'b1, "R6", "disabled local reset ignored");
    pt_rst = 0;
  endtask

  task automatic test_block_init;
    do_cfg(3'd1, 2'd3, 1, 0, 0, 0);
    d = 1; pulse(1);
    blk_init = 1; #1 chk(1'b0, "R6", "block init resets");
    blk_init = 0;
    do_cfg(3'd1, 2'd3, 1, 0, 0, 1);
    d = 0; pulse(1);
    blk_init = 1; #1 chk(1'b1, "R6", "swapped block init sets");
    blk_init = 0;
    do_cfg(3'd1, 2'd3, 0, 0, 0, 1);
    d = 1; pulse(1);
    blk_init = 1; #1 chk(1'b1, "R6", "unused block init ignored");
    d = 0; pulse(1);
    chk(1'b0, "R6", "clock still works with init line high");
    blk_init = 0;
  endtask

  task automatic test_cfg_frozen;
    do_cfg(3'd1, 2'd3, 0, 0, 0, 0);
    cfg_clk_sel = 3'd7; cfg_ce_sel = 2'd0; ce_pt = 0;
    cfg_init_en = 1; cfg_swap = 1;
    d = 1; pulse(1);
    chk(1'b1, "R8", "late clock/enable change ignored");
    blk_init = 1; #1 chk(1'b1, "R8", "late init enable ignored");
    blk_init = 0;
  endtask

  initial begin
    test_power_up();
    test_clk_sel();
    test_ce();
    test_local();
    test_block_init();
    test_cfg_frozen();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule